// File: doc/BRIEF.md
# Memory Write Protection Controller

This block guards the write path into a 272-byte nonvolatile array (byte addresses 000h to 10Fh). A serial-bus decoder upstream presents a 9-bit target address, a data byte and a one-cycle write strobe. The block decides in the same cycle whether that write may reach the array. Permitted writes are forwarded unchanged. Forbidden writes are dropped without any effect on the array, and each one sets a sticky rejection flag that software can read and clear.

The decision depends on two lock configuration bits and an active-low write-protect pin. The lock bits grow the protected area in steps. The first step covers the general-purpose area at 000h–07Fh. The second adds the first lookup table at 090h–0CFh. The third adds the second lookup table at 0D0h–10Fh. The control window at 080h–08Fh is never covered by the lock bits, so the lock setting itself stays writable. When the pin is low, it blocks every write regardless of the lock bits. Reads do not pass through this block and are never affected.

Top module: `wprot_ctrl`

## Requirements
- R1: With lock code 0 (binary 00) and the pin high, a write to any address from 000h to 10Fh is forwarded.
- R2: With lock code 1 (binary 01) and the pin high, writes to 000h–07Fh are blocked and writes to 080h–10Fh are forwarded.
- R3: With lock code 2 (binary 10) and the pin high, writes to 000h–07Fh and 090h–0CFh are blocked, and writes to 080h–08Fh and 0D0h–10Fh are forwarded.
- R4: With lock code 3 (binary 11) and the pin high, writes to 000h–07Fh and 090h–10Fh are blocked, and writes to 080h–08Fh are forwarded.
- R5: Writes to 080h–08Fh are forwarded under every lock code while the pin is high.
- R6: While the write-protect pin is low, no write is forwarded, at any address and under any lock code.
- R7: A forwarded write raises the array write enable in the same cycle as the strobe. The array address and data equal the request address and data.
- R8: A blocked write leaves the array write enable low in that cycle.
- R9: A strobe whose write is blocked sets the rejection flag at the next clock edge. The flag then stays set until it is cleared.
- R10: A clear pulse resets the flag at the next edge. If a blocked write arrives in the same cycle as the clear, the flag is set.
- R11: Without a strobe, the array write enable stays low and the flag does not change.
- R12: A write to an address above 10Fh is never forwarded and counts as a rejection.
- R13: The flag reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write strobe from the bus decoder |
| wr_addr | input | 9 | Target byte address |
| wr_data | input | 8 | Byte to be written |
| lock_cfg | input | 2 | Lock code: 0 none, 1 general area, 2 adds table A, 3 adds both tables |
| wp_n | input | 1 | Write-protect pin, low blocks all writes |
| flag_clr | input | 1 | Pulse that clears the rejection flag |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 9 | Array address |
| arr_data | output | 8 | Array write data |
| rej_flag | output | 1 | Sticky write-rejected flag |

## Verification
Directed sweeps take each lock code across both edges of every region boundary (07Fh/080h, 08Fh/090h, 0CFh/0D0h, 10Fh/110h). A mistake in any single range comparison therefore shows up as a wrong forward or block decision. Random traffic mixes all lock codes, addresses across the full 9-bit space, occasional low pin levels, idle cycles and clear pulses. This separates the pin override from the lock decode, and idle strobes from real requests. Cycles where a clear and a rejection coincide check the priority of the flag update.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    LK_OPEN  = 2'd0,
    LK_GEN   = 2'd1,
    LK_GEN_A = 2'd2,
    LK_ALL   = 2'd3
  } lock_e;

  typedef enum logic [2:0] {
    RG_GEN  = 3'd0,
    RG_CTL  = 3'd1,
    RG_TBLA = 3'd2,
    RG_TBLB = 3'd3,
    RG_NONE = 3'd4
  } region_e;

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wprot_region_dec.sv
module wprot_region_dec
  import wprot_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int GEN_HI  = 'h07F,
  parameter int CTL_HI  = 'h08F,
  parameter int TBLA_HI = 'h0CF,
  parameter int TBLB_HI = 'h10F
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] GEN_END  = ADDR_W'(GEN_HI);
  localparam logic [ADDR_W-1:0] CTL_END  = ADDR_W'(CTL_HI);
  localparam logic [ADDR_W-1:0] TBLA_END = ADDR_W'(TBLA_HI);
  localparam logic [ADDR_W-1:0] TBLB_END = ADDR_W'(TBLB_HI);

  always_comb begin
    if (addr <= GEN_END)       region = RG_GEN;
    else if (addr <= CTL_END)  region = RG_CTL;
    else if (addr <= TBLA_END) region = RG_TBLA;
    else if (addr <= TBLB_END) region = RG_TBLB;
    else                       region = RG_NONE;
  end
endmodule

// File: rtl/wprot_policy.sv
module wprot_policy
  import wprot_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  region_e region,
  input  lock_e   lock,
  input  logic    wp_n,
  output logic    allow
);
  logic lock_hit;

  always_comb begin
    lock_hit = 1'b0;
    unique case (region)
      RG_GEN:  lock_hit = (lock != LK_OPEN);
      RG_TBLA: lock_hit = (lock == LK_GEN_A) || (lock == LK_ALL);
      RG_TBLB: lock_hit = (lock == LK_ALL);
      RG_CTL:  lock_hit = 1'b0;
      default: lock_hit = 1'b1;
    endcase
  end

  assign allow = wp_n && !lock_hit;

  assert_ctl_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_CTL && wp_n) |-> allow);

  assert_pin_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !allow);
endmodule

// File: rtl/wprot_sticky.sv
module wprot_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int GEN_HI  = 'h07F,
  parameter int CTL_HI  = 'h08F,
  parameter int TBLA_HI = 'h0CF,
  parameter int TBLB_HI = 'h10F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        lock_cfg,
  input  logic              wp_n,
  input  logic              flag_clr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              rej_flag
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TBLB_HI);

  logic    rst_sync_n;
  region_e region;
  logic    allow;
  logic    reject;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wprot_region_dec #(
    .ADDR_W  (ADDR_W),
    .GEN_HI  (GEN_HI),
    .CTL_HI  (CTL_HI),
    .TBLA_HI (TBLA_HI),
    .TBLB_HI (TBLB_HI)
  ) u_dec (
    .addr   (wr_addr),
    .region (region)
  );

  wprot_policy u_pol (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .region (region),
    .lock   (lock_e'(lock_cfg)),
    .wp_n   (wp_n),
    .allow  (allow)
  );

  always_comb begin
    arr_we   = wr_req && allow;
    reject   = wr_req && !allow;
    arr_addr = wr_addr;
    arr_data = wr_data;
  end

  wprot_sticky u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (reject),
    .clr_i  (flag_clr),
    .flag_o (rej_flag)
  );

  assert_we_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> wr_req);

  assert_no_we_pin_low_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wp_n |-> !arr_we);

  assert_out_of_range_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && wr_addr > LAST_ADDR) |=> rej_flag);

  assert_gen_locked_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lock_cfg != 2'd0 && wr_addr <= ADDR_W'(GEN_HI)) |-> !arr_we);
endmodule

// File: tb/wprot_ctrl_tb.sv
module wprot_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_req;
  logic [8:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] lock_cfg;
  logic       wp_n;
  logic       flag_clr;
  logic       arr_we;
  logic [8:0] arr_addr;
  logic [7:0] arr_data;
  logic       rej_flag;

  int total = 0;
  int bad   = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock_cfg(lock_cfg), .wp_n(wp_n), .flag_clr(flag_clr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .rej_flag(rej_flag)
  );

  function automatic bit exp_allow(input logic [8:0] a, input logic [1:0] lk, input logic pin);
    bit blk;
    if (!pin) return 1'b0;
    if (a > 9'h10F) return 1'b0;
    blk = 1'b0;
    if (a <= 9'h07F && lk != 2'd0) blk = 1'b1;
    if (a >= 9'h090 && a <= 9'h0CF && lk >= 2'd2) blk = 1'b1;
    if (a >= 9'h0D0 && a <= 9'h10F && lk == 2'd3) blk = 1'b1;
    return !blk;
  endfunction

  function automatic string req_tag(input logic [8:0] a, input logic [1:0] lk, input logic pin);
    if (!pin) return "R6";
    if (a > 9'h10F) return "R12";
    if (a >= 9'h080 && a <= 9'h08F) return "R5";
    case (lk)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit rq, input logic [8:0] a, input logic [7:0] d,
                      input logic [1:0] lk, input logic pin, input bit clr);
    bit al;
    bit we_exp;
    @(negedge clk);
    wr_req = rq; wr_addr = a; wr_data = d; lock_cfg = lk; wp_n = pin; flag_clr = clr;
    #1;
    al = exp_allow(a, lk, pin);
    we_exp = rq && al;
    if (!rq)
      check(arr_we == 1'b0, "R11 idle we", arr_we, 0);
    else if (al)
      check(arr_we == 1'b1, {req_tag(a, lk, pin), " R7 forward"}, arr_we, 1);
    else
      check(arr_we == 1'b0, {req_tag(a, lk, pin), " R8 block"}, arr_we, 0);
    if (we_exp) begin
      check(arr_addr == a, "R7 addr", arr_addr, a);
      check(arr_data == d, "R7 data", arr_data, d);
    end
    if (rq && !al) exp_flag = 1'b1;
    else if (clr)  exp_flag = 1'b0;
    @(posedge clk);
    #1;
    if (rq && !al)
      check(rej_flag == exp_flag, "R9 flag set", rej_flag, exp_flag);
    else if (clr)
      check(rej_flag == exp_flag, "R10 flag clear", rej_flag, exp_flag);
    else
      check(rej_flag == exp_flag, "R11 flag hold", rej_flag, exp_flag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [8:0] edges [8];
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_data = '0;
    lock_cfg = 2'd0; wp_n = 1'b1; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(rej_flag == 1'b0, "R13 reset flag", rej_flag, 0);

    edges[0] = 9'h000; edges[1] = 9'h07F; edges[2] = 9'h080; edges[3] = 9'h08F;
    edges[4] = 9'h090; edges[5] = 9'h0CF; edges[6] = 9'h0D0; edges[7] = 9'h10F;
    for (int lk = 0; lk < 4; lk++) begin
      for (int e = 0; e < 8; e++)
        step(1'b1, edges[e], 8'(e * 17 + lk), 2'(lk), 1'b1, 1'b0);
      step(1'b1, 9'h110, 8'hA5, 2'(lk), 1'b1, 1'b0);
      step(1'b1, 9'h1FF, 8'h5A, 2'(lk), 1'b1, 1'b0);
      step(1'b0, 9'h000, 8'h00, 2'(lk), 1'b1, 1'b1);
      step(1'b1, 9'h085, 8'h3C, 2'(lk), 1'b0, 1'b0);
      step(1'b0, 9'h085, 8'h00, 2'(lk), 1'b1, 1'b0);
    end
    // R10: clear and rejection in the same cycle, rejection wins
    step(1'b1, 9'h010, 8'h11, 2'd1, 1'b1, 1'b1);
    step(1'b0, 9'h010, 8'h00, 2'd1, 1'b1, 1'b1);
    step(1'b1, 9'h080, 8'h22, 2'd3, 1'b0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] a;
      a = ($urandom % 2) ? 9'($urandom % 272) : 9'($urandom);
      step(($urandom % 8) != 0, a, 8'($urandom), 2'($urandom),
           ($urandom % 8) != 0, ($urandom % 10) == 0);
    end
    finish_run();
  end
endmodule